// File: doc/BRIEF.md
# Warp Issue Scheduler

The block picks one warp out of a pool of resident warps each time the dispatch port is free and issues that warp's next instruction to a SIMD lane array. A warp can take part only when two things are true: its resident bit is set, and its operand-ready input says that the source operands of its next instruction are available. Among the warps that can take part, the one with the lowest index wins. Every thread of the chosen warp runs that same instruction.

Each issued instruction holds the dispatch port for a fixed number of cycles, four by default, while it is sent across all lanes. A phase output counts through those cycles. The slot is arbitrated again in the last cycle of a dispatch. So a different warp can follow in the very next cycle and a change of warp costs no cycles. Fetch, decode and register files sit outside the block. They appear only as a per-warp ready input and a per-warp one-cycle consume pulse, which tells the fetch side that the instruction has been taken. Launch and retire inputs set and clear the resident bits.

Top module: `warp_issue_sched`

## Requirements
- R1: While and after synchronous reset (`rst` high at a clock edge), no warp is resident, `issue_valid` is 0, `idle_cycle` is 1, `issue_warp_id` is 0, `dispatch_phase` is 0 and `warp_consume` is all zeros.
- R2: A 1 on `warp_launch[i]` at a clock edge makes warp i resident, and a 1 on `warp_retire[i]` clears it. When both are 1 for the same warp, retire wins. The new resident state is used by selections from the following cycle on.
- R3: A warp is selected only if, in the selection cycle, it is resident and its `operand_ready` bit is 1.
- R4: Among eligible warps, the one with the lowest index is selected.
- R5: A selection made in cycle c produces a dispatch in cycles c+1 to c+4. Through those cycles `issue_valid` is 1, `issue_warp_id` holds the selected index and `dispatch_phase` counts 0, 1, 2, 3.
- R6: `warp_consume` is one-hot for the issuing warp in the phase-0 cycle of a dispatch and is zero in every other cycle.
- R7: In phases 0, 1 and 2 no selection takes place. Changes of `operand_ready` in those cycles have no effect on the dispatch in flight or on the next issue.
- R8: The slot is arbitrated in the phase-3 cycle. When a warp is eligible then, the next dispatch starts phase 0 in the very next cycle, with no gap.
- R9: When the slot is open and no warp is eligible, the next cycle shows `issue_valid` 0, `idle_cycle` 1, `issue_warp_id` 0, `dispatch_phase` 0 and no consume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| warp_launch | input | NUM_WARPS | Per-warp request to make the warp resident |
| warp_retire | input | NUM_WARPS | Per-warp request to clear residency; wins over launch |
| operand_ready | input | NUM_WARPS | Per-warp flag: operands of the next instruction are available |
| issue_valid | output | 1 | A warp instruction occupies the dispatch port this cycle |
| issue_warp_id | output | $clog2(NUM_WARPS) | Index of the dispatching warp, 0 when idle |
| dispatch_phase | output | $clog2(DISPATCH_CYCLES) | Lane-group phase of the current dispatch, 0 when idle |
| warp_consume | output | NUM_WARPS | One-cycle pulse to the fetch side of the issuing warp |
| idle_cycle | output | 1 | The dispatch port is empty this cycle |

## Verification
The bench sweeps every ready mask with all warps resident, then every resident mask with all operands ready. A picker that mis-encoded an index, or that let a lower-priority warp win, would show a wrong `issue_warp_id` or a wrong consume bit in some vector. Back-to-back runs go after the phase-3 arbitration point: a design that arbitrated only once it was idle would insert a dead cycle, and one that arbitrated earlier would cut a dispatch short or pulse consume mid-dispatch. Ready toggling during phases 0 to 2, same-cycle launch and retire of one warp, and all-not-ready windows expose a scheduler that samples too early, lets launch win, or leaves a stale warp id on the port while idle.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    typedef enum logic {
        PORT_FREE = 1'b0,
        PORT_BUSY = 1'b1
    } port_state_e;

    localparam int unsigned DEF_NUM_WARPS       = 8;
    localparam int unsigned DEF_DISPATCH_CYCLES = 4;

    // Next resident state of one warp: retire wins over launch.
    function automatic logic next_resident(input logic cur, input logic launch, input logic retire);
        return (cur | launch) & ~retire;
    endfunction

endpackage

// File: rtl/warp_valid_table.sv
module warp_valid_table
    import warp_sched_pkg::*;
#(
    parameter int unsigned NUM_WARPS = DEF_NUM_WARPS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] launch,
    input  logic [NUM_WARPS-1:0] retire,
    output logic [NUM_WARPS-1:0] resident
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                resident[w] <= 1'b0;
            end else begin
                resident[w] <= next_resident(resident[w], launch[w], retire[w]);
            end
        end
    end

endmodule

// File: rtl/warp_priority_pick.sv
module warp_priority_pick #(
    parameter int unsigned NUM_WARPS = 8,
    localparam int unsigned ID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic [NUM_WARPS-1:0] req,
    output logic [NUM_WARPS-1:0] grant,
    output logic [ID_W-1:0]      grant_id,
    output logic                 any_req
);

    // taken[i] is set when some warp below index i is requesting.
    logic [NUM_WARPS:0] taken;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_chain
        assign grant[i]   = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end

    assign any_req = taken[NUM_WARPS];

    always_comb begin
        grant_id = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (grant[i]) begin
                grant_id = grant_id | ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/warp_dispatch_timer.sv
module warp_dispatch_timer
    import warp_sched_pkg::*;
#(
    parameter int unsigned DISPATCH_CYCLES = DEF_DISPATCH_CYCLES,
    localparam int unsigned PHASE_W        = $clog2(DISPATCH_CYCLES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               slot_open,
    output logic               busy,
    output logic [PHASE_W-1:0] phase
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(DISPATCH_CYCLES - 1);

    port_state_e state_q;

    assign busy      = (state_q == PORT_BUSY);
    assign slot_open = !busy || (phase == LAST_PHASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PORT_FREE;
            phase   <= '0;
        end else if (slot_open) begin
            state_q <= start ? PORT_BUSY : PORT_FREE;
            phase   <= '0;
        end else begin
            phase   <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int unsigned NUM_WARPS       = DEF_NUM_WARPS,
    parameter int unsigned DISPATCH_CYCLES = DEF_DISPATCH_CYCLES,
    localparam int unsigned ID_W           = $clog2(NUM_WARPS),
    localparam int unsigned PHASE_W        = $clog2(DISPATCH_CYCLES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] warp_launch,
    input  logic [NUM_WARPS-1:0] warp_retire,
    input  logic [NUM_WARPS-1:0] operand_ready,
    output logic                 issue_valid,
    output logic [ID_W-1:0]      issue_warp_id,
    output logic [PHASE_W-1:0]   dispatch_phase,
    output logic [NUM_WARPS-1:0] warp_consume,
    output logic                 idle_cycle
);

    logic [NUM_WARPS-1:0] warp_valid;
    logic [NUM_WARPS-1:0] eligible;
    logic [NUM_WARPS-1:0] pick_grant;
    logic [ID_W-1:0]      pick_id;
    logic                 pick_any;
    logic                 slot_open;
    logic                 port_busy;
    logic                 take;

    warp_valid_table #(.NUM_WARPS(NUM_WARPS)) valid_i (
        .clk      (clk),
        .rst      (rst),
        .launch   (warp_launch),
        .retire   (warp_retire),
        .resident (warp_valid)
    );

    assign eligible = warp_valid & operand_ready;

    warp_priority_pick #(.NUM_WARPS(NUM_WARPS)) pick_i (
        .req      (eligible),
        .grant    (pick_grant),
        .grant_id (pick_id),
        .any_req  (pick_any)
    );

    assign take = slot_open & pick_any;

    warp_dispatch_timer #(.DISPATCH_CYCLES(DISPATCH_CYCLES)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .start     (pick_any),
        .slot_open (slot_open),
        .busy      (port_busy),
        .phase     (dispatch_phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_warp_id <= '0;
            warp_consume  <= '0;
        end else if (slot_open) begin
            issue_warp_id <= take ? pick_id : '0;
            warp_consume  <= take ? pick_grant : '0;
        end else begin
            warp_consume  <= '0;
        end
    end

    assign issue_valid = port_busy;
    assign idle_cycle  = ~port_busy;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
    parameter int unsigned NUM_WARPS       = 8,
    parameter int unsigned DISPATCH_CYCLES = 4,
    localparam int unsigned ID_W           = $clog2(NUM_WARPS),
    localparam int unsigned PHASE_W        = $clog2(DISPATCH_CYCLES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WARPS-1:0] operand_ready,
    input logic [NUM_WARPS-1:0] warp_valid,
    input logic                 issue_valid,
    input logic [ID_W-1:0]      issue_warp_id,
    input logic [PHASE_W-1:0]   dispatch_phase,
    input logic [NUM_WARPS-1:0] warp_consume
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(DISPATCH_CYCLES - 1);

    AST_CONSUME_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(warp_consume)); // R6

    AST_CONSUME_AT_START: assert property (@(posedge clk) disable iff (rst)
        (|warp_consume) |-> (issue_valid && dispatch_phase == '0 && warp_consume[issue_warp_id])); // R6

    AST_NO_MIDSTART: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && dispatch_phase != '0) |-> (warp_consume == '0)); // R7

    AST_HOLD_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && dispatch_phase != LAST_PHASE) |=>
            (issue_valid && $stable(issue_warp_id) && dispatch_phase == $past(dispatch_phase) + 1'b1)); // R5

    AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        (|warp_consume) |-> (($past(operand_ready & warp_valid) & warp_consume) != '0)); // R3

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (|warp_consume) |-> (((warp_consume - NUM_WARPS'(1)) & $past(operand_ready & warp_valid)) == '0)); // R4

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (issue_warp_id == '0 && dispatch_phase == '0)); // R9

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
    .NUM_WARPS       (NUM_WARPS),
    .DISPATCH_CYCLES (DISPATCH_CYCLES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .operand_ready  (operand_ready),
    .warp_valid     (warp_valid),
    .issue_valid    (issue_valid),
    .issue_warp_id  (issue_warp_id),
    .dispatch_phase (dispatch_phase),
    .warp_consume   (warp_consume)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb_top;

    localparam int unsigned NW      = 8;
    localparam int unsigned DC      = 4;
    localparam int unsigned IDW     = $clog2(NW);
    localparam int unsigned PW      = $clog2(DC);
    localparam time         CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic [NW-1:0] warp_launch;
    logic [NW-1:0] warp_retire;
    logic [NW-1:0] operand_ready;
    logic          issue_valid;
    logic [IDW-1:0] issue_warp_id;
    logic [PW-1:0] dispatch_phase;
    logic [NW-1:0] warp_consume;
    logic          idle_cycle;

    int n_checks = 0;
    int n_fails  = 0;

    // bench-side expectation state
    logic [NW-1:0]  m_valid;
    logic           m_busy;
    logic [PW-1:0]  m_phase;
    logic [IDW-1:0] m_id;
    logic [NW-1:0]  m_consume;

    always #(CLK_PER/2) clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .DISPATCH_CYCLES(DC)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .warp_launch    (warp_launch),
        .warp_retire    (warp_retire),
        .operand_ready  (operand_ready),
        .issue_valid    (issue_valid),
        .issue_warp_id  (issue_warp_id),
        .dispatch_phase (dispatch_phase),
        .warp_consume   (warp_consume),
        .idle_cycle     (idle_cycle)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "issue_valid", int'(issue_valid), int'(m_busy));
        check(tag, "idle_cycle", int'(idle_cycle), int'(!m_busy));
        check(tag, "issue_warp_id", int'(issue_warp_id), int'(m_id));
        check(tag, "dispatch_phase", int'(dispatch_phase), int'(m_phase));
        check(tag, "warp_consume", int'(warp_consume), int'(m_consume));
    endtask

    // One clock: drive at negedge, predict, sample 1ns after the rising edge.
    task automatic step(input logic [NW-1:0] launch, input logic [NW-1:0] retire,
                        input logic [NW-1:0] ready, input string tag);
        logic [NW-1:0] elig;
        logic          open;
        int            win;
        @(negedge clk);
        warp_launch   = launch;
        warp_retire   = retire;
        operand_ready = ready;
        elig = m_valid & ready;
        open = !m_busy || (m_phase == PW'(DC - 1));
        win  = -1;
        for (int i = NW - 1; i >= 0; i--) begin
            if (elig[i]) win = i;
        end
        if (open) begin
            m_phase = '0;
            if (win >= 0) begin
                m_busy    = 1'b1;
                m_id      = IDW'(win);
                m_consume = NW'(1) << win;
            end else begin
                m_busy    = 1'b0;
                m_id      = '0;
                m_consume = '0;
            end
        end else begin
            m_phase   = m_phase + 1'b1;
            m_consume = '0;
        end
        m_valid = (m_valid | launch) & ~retire;
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        warp_launch = '0; warp_retire = '0; operand_ready = '0;
        @(posedge clk); @(posedge clk); #1;
        m_valid = '0; m_busy = 1'b0; m_phase = '0; m_id = '0; m_consume = '0;
        compare_all("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1;
        warp_launch = '0; warp_retire = '0; operand_ready = '0;
        m_valid = '0; m_busy = 1'b0; m_phase = '0; m_id = '0; m_consume = '0;

        // R1: reset state
        do_reset();
        // R1: nothing resident, so all-ready still idles
        step('0, '0, '1, "R1");

        // R2: launch every warp; usable from the next cycle
        step('1, '0, '0, "R2");

        // R4: sweep every ready mask, each held across a full dispatch window
        for (int p = 0; p < (1 << NW); p++) begin
            for (int c = 0; c < DC; c++) step('0, '0, NW'(p), "R4");
        end

        // R8: back-to-back dispatches, port never empties
        for (int c = 0; c < 4 * DC; c++) begin
            step('0, '0, '1, "R8");
            check("R8", "continuous issue_valid", int'(issue_valid), 1);
        end

        // R9: nothing ready drains to idle
        for (int c = 0; c < DC + 2; c++) step('0, '0, '0, "R9");

        // R3: sweep resident masks through launch/retire with all operands ready
        for (int p = 0; p < (1 << NW); p++) begin
            step(NW'(p), ~NW'(p), '0, "R2");
            for (int c = 0; c < DC; c++) step('0, '0, '1, "R3");
            for (int c = 0; c < DC; c++) step('0, '0, '0, "R3");
        end

        // R2: same-cycle launch and retire of warp 0 leaves it absent
        do_reset();
        step(NW'(1), NW'(1), '0, "R2");
        step('0, '0, NW'(1), "R2");
        check("R2", "retire wins, no issue", int'(issue_valid), 0);

        // R7: ready changes mid-dispatch are ignored
        step('1, '0, '0, "R7");
        step('0, '0, NW'(8'h80), "R7");
        check("R7", "issued warp 7", int'(issue_warp_id), 7);
        step('0, '0, NW'(8'h01), "R7");
        step('0, '0, NW'(8'h02), "R7");
        step('0, '0, NW'(8'h04), "R7");
        check("R7", "still warp 7 at last phase", int'(issue_warp_id), 7);
        step('0, '0, NW'(8'h10), "R8");
        check("R8", "next warp 4 without gap", int'(issue_warp_id), 4);

        // R3: pseudo-random mixed traffic
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(NW'(lfsr[7:0] & {NW{lfsr[8] & lfsr[9]}}),
                 NW'(lfsr[15:8] & {NW{lfsr[3] & lfsr[5]}}),
                 NW'(lfsr[11:4]), "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule